// File: doc/BRIEF.md
# Offline Switcher Fault Supervisor

This block decides when the power switch of an offline flyback controller may run. It reads digital comparator flags for the supply rail (turn-on, turn-off, raised-discharge level, restart level, latch-release level, rail over-voltage), for the rectified line (brown-in, brown-out, line over-voltage and its release level), for feedback open-loop and for over-temperature. It also receives single-cycle fault pulses from the PWM sequencer (abnormal over-current and current-sense short) and a tick once per switching cycle.

Rail and line over-voltage are qualified by counting consecutive switching pulses. Brown-out, open-loop and soft-start are timed on a slow tick made by a free-running prescaler; a time qualifier restarts from zero whenever its condition lapses. Each fault class has its own recovery path. Rail over-voltage and open-loop take the auto-restart route, which ends at the restart level. Line faults wait for the line to return. Over-temperature waits for the temperature flag to clear. The sequencer faults latch until the rail collapses to the latch-release level. The outputs are plain control levels: switching enable, soft-start request, high-voltage startup current enable and a supply-current mode code.

Top module: `psu_fault_supervisor`

## Requirements
- R1: After reset, switching and soft-start are off, the startup current is on and cur_mode is 0 (normal).
- R2: Switching starts only when vcc_above_on and line_above_bi are both high. It starts with soft_start high and the startup current off. After SS_TICKS slow ticks, soft_start drops and switching continues.
- R3: A rail over-voltage (vcc_ovp) disables switching only after PULSE_DEB consecutive pulse_tick cycles with the flag high. If the flag drops before then, the count restarts.
- R4: A line over-voltage held for PULSE_DEB pulses stops switching. The block restarts with soft-start only once line_ovp_rel and vcc_above_on are both high.
- R5: Brown-out trips when line_below_bo holds for BO_TICKS slow ticks, and any lapse restarts the timing. Recovery needs line_above_bi and vcc_above_on.
- R6: If fb_open holds for OLP_TICKS slow ticks, switching stops and the auto-restart sequence begins.
- R7: Auto-restart selects cur_mode 1 (idle) first and then cur_mode 2 (raised discharge) once vcc_above_sop is low. When vcc_above_ar goes low, the block returns to the charging state with the startup current on and cur_mode 0.
- R8: An aocp_fault or cssp_fault pulse during switching selects cur_mode 3 (latched hold) and stops switching. In this state the startup current turns on when vcc_above_ar is low and off when vcc_above_on is high, and switching stays off even when the start conditions hold. Only a low vcc_above_lr releases the state to charging.
- R9: While tsd is high, switching is off and the startup current follows the same AR/ON hysteresis. Once tsd clears, the block goes back through charging to a fresh start.
- R10: If vcc_above_off goes low during switching, switching stops and charging resumes with the startup current on.
- R11: A sequencer fault arriving in the same cycle as any other fault wins and leads to the latched hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_above_on | input | 1 | Rail above turn-on level |
| vcc_above_off | input | 1 | Rail above turn-off level |
| vcc_above_sop | input | 1 | Rail above raised-discharge level |
| vcc_above_ar | input | 1 | Rail above restart level |
| vcc_above_lr | input | 1 | Rail above latch-release level |
| vcc_ovp | input | 1 | Rail over-voltage flag |
| line_above_bi | input | 1 | Line above brown-in level |
| line_below_bo | input | 1 | Line below brown-out level |
| line_ovp | input | 1 | Line over-voltage flag |
| line_ovp_rel | input | 1 | Line below over-voltage release level |
| fb_open | input | 1 | Feedback at open-loop level |
| tsd | input | 1 | Over-temperature flag (hysteresis outside) |
| pulse_tick | input | 1 | One cycle per switching period |
| aocp_fault | input | 1 | Abnormal over-current pulse from sequencer |
| cssp_fault | input | 1 | Current-sense short pulse from sequencer |
| sw_en | output | 1 | Switching allowed |
| soft_start | output | 1 | Soft-start in progress |
| hv_start_en | output | 1 | High-voltage startup current enable |
| cur_mode | output | 2 | 0 normal, 1 idle, 2 raised discharge, 3 latched hold |

## Verification
The assertions check the following on every cycle:
- switching never rises without the turn-on flag;
- a sequencer fault during switching always lands in the latched hold;
- idle current gives way once the rail falls below the raised-discharge level;
- an undervoltage or an over-temperature always ends switching on the next cycle;
- no qualifier can report a trip unless its condition was present.

Other behaviour shows only in the bench's scenarios:
- how many pulses or slow ticks a fault must persist;
- that an interrupted condition restarts the count;
- that the latched hold withholds switching while its startup current cycles;
- the exact release conditions of each recovery path.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  typedef enum logic [2:0] {
    ST_CHARGE, ST_SOFT, ST_RUN, ST_FAULT, ST_LINE, ST_TSD, ST_LATCH
  } sup_state_t;

  typedef enum logic [1:0] {
    CUR_NORMAL = 2'd0,
    CUR_IDLE   = 2'd1,
    CUR_DRAIN  = 2'd2,
    CUR_HOLD   = 2'd3
  } cur_mode_t;
endpackage

// File: rtl/fsup_prescaler.sv
module fsup_prescaler #(
  parameter int PRESCALE = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic slow_tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                    div_q <= div_q + 1'b1;
  end

  assign slow_tick = (div_q == LAST);
endmodule

// File: rtl/fsup_pulse_deb.sv
module fsup_pulse_deb #(
  parameter int COUNT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic cond_i,
  input  logic pulse_i,
  output logic trip_o
);
  localparam int CW = $clog2(COUNT + 1);
  localparam logic [CW-1:0] FULL = CW'(COUNT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (!enable || !cond_i)   cnt_q <= '0;
    else if (pulse_i && cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
  end

  assign trip_o = (cnt_q == FULL);

  // R3
  pulse_trip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_o |-> $past(cond_i));
endmodule

// File: rtl/fsup_time_deb.sv
module fsup_time_deb #(
  parameter int LIMIT = 70
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic cond_i,
  input  logic slow_tick,
  output logic trip_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] FULL = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (!enable || !cond_i)     cnt_q <= '0;
    else if (slow_tick && cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
  end

  assign trip_o = (cnt_q == FULL);

  // R5
  time_trip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_o |-> $past(cond_i));
endmodule

// File: rtl/psu_fault_supervisor.sv
module psu_fault_supervisor
  import fsup_pkg::*;
#(
  parameter int PRESCALE  = 16,
  parameter int PULSE_DEB = 6,
  parameter int BO_TICKS  = 70,
  parameter int OLP_TICKS = 60,
  parameter int SS_TICKS  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_above_on,
  input  logic       vcc_above_off,
  input  logic       vcc_above_sop,
  input  logic       vcc_above_ar,
  input  logic       vcc_above_lr,
  input  logic       vcc_ovp,
  input  logic       line_above_bi,
  input  logic       line_below_bo,
  input  logic       line_ovp,
  input  logic       line_ovp_rel,
  input  logic       fb_open,
  input  logic       tsd,
  input  logic       pulse_tick,
  input  logic       aocp_fault,
  input  logic       cssp_fault,
  output logic       sw_en,
  output logic       soft_start,
  output logic       hv_start_en,
  output logic [1:0] cur_mode
);
  localparam int NPULSE = 2;
  localparam int SW = $clog2(SS_TICKS + 1);
  localparam logic [SW-1:0] SS_END = SW'(SS_TICKS);

  sup_state_t  state_q, state_d;
  logic        slow_tick;
  logic        switching;
  logic [NPULSE-1:0] pulse_cond, pulse_trip;
  logic        bo_trip, olp_trip;
  logic [SW-1:0] ss_q;
  logic        line_cause_ovp_q, line_cause_ovp_d;
  logic        hv_cyc_q, drain_q;
  logic        latch_ev, start_ok, hv_cycling;

  assign switching = (state_q == ST_SOFT) || (state_q == ST_RUN);

  fsup_prescaler #(.PRESCALE(PRESCALE)) i_presc (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick)
  );

  // index 0: rail over-voltage, index 1: line over-voltage
  assign pulse_cond = {line_ovp, vcc_ovp};
  for (genvar g = 0; g < NPULSE; g++) begin : g_pdeb
    fsup_pulse_deb #(.COUNT(PULSE_DEB)) i_pdeb (
      .clk(clk), .rst_n(rst_n), .enable(switching),
      .cond_i(pulse_cond[g]), .pulse_i(pulse_tick), .trip_o(pulse_trip[g])
    );
  end

  fsup_time_deb #(.LIMIT(BO_TICKS)) i_bo_deb (
    .clk(clk), .rst_n(rst_n), .enable(switching), .cond_i(line_below_bo),
    .slow_tick(slow_tick), .trip_o(bo_trip)
  );

  fsup_time_deb #(.LIMIT(OLP_TICKS)) i_olp_deb (
    .clk(clk), .rst_n(rst_n), .enable(switching), .cond_i(fb_open),
    .slow_tick(slow_tick), .trip_o(olp_trip)
  );

  assign latch_ev = aocp_fault || cssp_fault;
  assign start_ok = vcc_above_on && line_above_bi;

  always_comb begin
    state_d = state_q;
    line_cause_ovp_d = line_cause_ovp_q;
    unique case (state_q)
      ST_CHARGE: begin
        if (tsd)           state_d = ST_TSD;
        else if (start_ok) state_d = ST_SOFT;
      end
      ST_SOFT, ST_RUN: begin
        if (latch_ev)                          state_d = ST_LATCH;
        else if (tsd)                          state_d = ST_TSD;
        else if (pulse_trip[0] || olp_trip)    state_d = ST_FAULT;
        else if (pulse_trip[1]) begin
          state_d = ST_LINE;
          line_cause_ovp_d = 1'b1;
        end else if (bo_trip) begin
          state_d = ST_LINE;
          line_cause_ovp_d = 1'b0;
        end else if (!vcc_above_off)           state_d = ST_CHARGE;
        else if (state_q == ST_SOFT && ss_q == SS_END) state_d = ST_RUN;
      end
      ST_FAULT: if (!vcc_above_ar) state_d = ST_CHARGE;
      ST_LINE: begin
        if (tsd) state_d = ST_TSD;
        else if (line_cause_ovp_q ? (line_ovp_rel && vcc_above_on) : start_ok)
          state_d = ST_SOFT;
      end
      ST_TSD:   if (!tsd) state_d = ST_CHARGE;
      ST_LATCH: if (!vcc_above_lr) state_d = ST_CHARGE;
      default:  state_d = ST_CHARGE;
    endcase
  end

  assign hv_cycling = (state_q == ST_LINE) || (state_q == ST_TSD) ||
                      (state_q == ST_LATCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q          <= ST_CHARGE;
      line_cause_ovp_q <= 1'b0;
      ss_q             <= '0;
      hv_cyc_q         <= 1'b0;
      drain_q          <= 1'b0;
    end else begin
      state_q          <= state_d;
      line_cause_ovp_q <= line_cause_ovp_d;
      if (state_q != ST_SOFT)              ss_q <= '0;
      else if (slow_tick && ss_q != SS_END) ss_q <= ss_q + 1'b1;
      if (!hv_cycling)        hv_cyc_q <= 1'b0;
      else if (!vcc_above_ar) hv_cyc_q <= 1'b1;
      else if (vcc_above_on)  hv_cyc_q <= 1'b0;
      if (state_q != ST_FAULT)  drain_q <= 1'b0;
      else if (!vcc_above_sop)  drain_q <= 1'b1;
    end
  end

  assign sw_en       = switching;
  assign soft_start  = (state_q == ST_SOFT);
  assign hv_start_en = (state_q == ST_CHARGE) || (hv_cycling && hv_cyc_q);

  always_comb begin
    unique case (state_q)
      ST_FAULT: cur_mode = drain_q ? CUR_DRAIN : CUR_IDLE;
      ST_LATCH: cur_mode = CUR_HOLD;
      default:  cur_mode = CUR_NORMAL;
    endcase
  end

  // R2
  start_needs_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_en) |-> $past(vcc_above_on));
  // R8
  latch_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && (aocp_fault || cssp_fault)) |=> (!sw_en && cur_mode == 2'd3));
  // R7
  idle_to_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 2'd1 && !vcc_above_sop) |=> (cur_mode != 2'd1));
  // R10
  uvlo_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && !vcc_above_off) |=> !sw_en);
  // R9
  tsd_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tsd |=> !sw_en);
endmodule

// File: tb/test_psu_fault_supervisor.sv
module test_psu_fault_supervisor;
  localparam int P   = 4;
  localparam int NP  = 6;
  localparam int BO  = 10;
  localparam int OLP = 8;
  localparam int SS  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_above_on, vcc_above_off, vcc_above_sop, vcc_above_ar, vcc_above_lr;
  logic vcc_ovp, line_above_bi, line_below_bo, line_ovp, line_ovp_rel;
  logic fb_open, tsd, pulse_tick, aocp_fault, cssp_fault;
  logic sw_en, soft_start, hv_start_en;
  logic [1:0] cur_mode;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  psu_fault_supervisor #(
    .PRESCALE(P), .PULSE_DEB(NP), .BO_TICKS(BO), .OLP_TICKS(OLP), .SS_TICKS(SS)
  ) i_psu_fault_supervisor (
    .clk(clk), .rst_n(rst_n),
    .vcc_above_on(vcc_above_on), .vcc_above_off(vcc_above_off),
    .vcc_above_sop(vcc_above_sop), .vcc_above_ar(vcc_above_ar),
    .vcc_above_lr(vcc_above_lr), .vcc_ovp(vcc_ovp),
    .line_above_bi(line_above_bi), .line_below_bo(line_below_bo),
    .line_ovp(line_ovp), .line_ovp_rel(line_ovp_rel), .fb_open(fb_open),
    .tsd(tsd), .pulse_tick(pulse_tick), .aocp_fault(aocp_fault),
    .cssp_fault(cssp_fault), .sw_en(sw_en), .soft_start(soft_start),
    .hv_start_en(hv_start_en), .cur_mode(cur_mode)
  );

  function automatic bit exp_pulse_trip(int n);
    return n >= NP;
  endfunction

  function automatic bit exp_time_trip(int held_cycles, int lim);
    // at most one slow tick per P cycles, rounded up
    return ((held_cycles + P - 1) / P) >= lim;
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic healthy();
    vcc_above_on = 1; vcc_above_off = 1; vcc_above_sop = 1;
    vcc_above_ar = 1; vcc_above_lr = 1; vcc_ovp = 0;
    line_above_bi = 1; line_below_bo = 0; line_ovp = 0; line_ovp_rel = 1;
    fb_open = 0; tsd = 0; pulse_tick = 0; aocp_fault = 0; cssp_fault = 0;
  endtask

  task automatic run_up();
    healthy();
    step(2);
    step((SS + 2) * P);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      pulse_tick = 1; step(1);
      pulse_tick = 0; step(1);
    end
  endtask

  task automatic rail_collapse();
    vcc_above_on = 0; vcc_above_sop = 0; vcc_above_ar = 0;
    step(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    healthy();
    line_above_bi = 0;
    step(3);
    chk("R1 sw_en", sw_en, 0);
    chk("R1 soft_start", soft_start, 0);
    chk("R1 hv_start_en", hv_start_en, 1);
    chk("R1 cur_mode", cur_mode, 0);
    rst_n = 1;
    step(10);
    chk("R2 no start below brown-in", sw_en, 0);
    line_above_bi = 1;
    step(2);
    chk("R2 sw_en at start", sw_en, 1);
    chk("R2 soft_start at start", soft_start, 1);
    chk("R2 hv off at start", hv_start_en, 0);
    step((SS + 2) * P);
    chk("R2 soft_start ends", soft_start, 0);
    chk("R2 still switching", sw_en, 1);

    // R3 random short bursts, interrupted
    for (int k = 0; k < 6; k++) begin
      int n = 1 + int'($urandom_range(NP - 2));
      vcc_ovp = 1;
      pulses(n);
      vcc_ovp = 0;
      step(1);
      chk("R3 no trip on short burst", sw_en, int'(!exp_pulse_trip(n)));
    end
    vcc_ovp = 1;
    pulses(NP - 1);
    chk("R3 one pulse short", sw_en, 1);
    pulses(1);
    step(1);
    chk("R3 trips at count", sw_en, 0);
    chk("R7 idle current", cur_mode, 1);
    vcc_ovp = 0;
    vcc_above_sop = 0;
    step(2);
    chk("R7 raised discharge", cur_mode, 2);
    vcc_above_ar = 0;
    vcc_above_on = 0;
    step(2);
    chk("R7 restart charging hv", hv_start_en, 1);
    chk("R7 restart cur normal", cur_mode, 0);
    chk("R7 restart no switching", sw_en, 0);

    // R4 line over-voltage
    run_up();
    line_ovp = 1; line_ovp_rel = 0;
    pulses(NP);
    step(1);
    chk("R4 line ovp trip", sw_en, 0);
    line_ovp = 0;
    step(6);
    chk("R4 holds before release", sw_en, 0);
    line_ovp_rel = 1;
    step(2);
    chk("R4 restart switching", sw_en, 1);
    chk("R4 restart soft", soft_start, 1);

    // R5 brown-out with random interrupted holds
    run_up();
    for (int k = 0; k < 4; k++) begin
      int len = 1 + int'($urandom_range((BO - 1) * P - 2));
      line_below_bo = 1; line_above_bi = 0;
      step(len);
      line_below_bo = 0;
      step(1);
      chk("R5 no trip on short sag", sw_en, int'(!exp_time_trip(len, BO)));
    end
    line_below_bo = 1;
    step((BO + 2) * P);
    chk("R5 brown-out trip", sw_en, 0);
    line_below_bo = 0;
    step(10);
    chk("R5 waits for brown-in", sw_en, 0);
    line_above_bi = 1;
    step(2);
    chk("R5 recovers", sw_en, 1);

    // R6 open loop
    run_up();
    fb_open = 1;
    step((OLP - 2) * P);
    chk("R6 not yet", sw_en, 1);
    step(4 * P);
    chk("R6 open-loop trip", sw_en, 0);
    chk("R6 auto-restart idle", cur_mode, 1);
    fb_open = 0;
    rail_collapse();
    chk("R6 back to charging", hv_start_en, 1);

    // R8 latched fault
    run_up();
    aocp_fault = 1; step(1); aocp_fault = 0;
    step(1);
    chk("R8 latch stop", sw_en, 0);
    chk("R8 latch cur", cur_mode, 3);
    chk("R8 hv off above AR", hv_start_en, 0);
    vcc_above_ar = 0; vcc_above_on = 0;
    step(2);
    chk("R8 hv on below AR", hv_start_en, 1);
    vcc_above_ar = 1; vcc_above_on = 1;
    step(4);
    chk("R8 hv off at ON", hv_start_en, 0);
    chk("R8 no switching while latched", sw_en, 0);
    vcc_above_on = 0; vcc_above_ar = 0; vcc_above_lr = 0;
    step(2);
    chk("R8 release cur", cur_mode, 0);
    chk("R8 release hv", hv_start_en, 1);

    // R11 priority of sequencer fault
    run_up();
    cssp_fault = 1; tsd = 1; fb_open = 1;
    step(1);
    cssp_fault = 0; tsd = 0; fb_open = 0;
    step(1);
    chk("R11 latch wins", cur_mode, 3);
    vcc_above_lr = 0; vcc_above_ar = 0; vcc_above_on = 0;
    step(2);

    // R9 thermal
    run_up();
    tsd = 1;
    step(2);
    chk("R9 thermal stop", sw_en, 0);
    vcc_above_ar = 0; vcc_above_on = 0;
    step(2);
    chk("R9 hv cycles on", hv_start_en, 1);
    vcc_above_ar = 1; vcc_above_on = 1;
    step(2);
    chk("R9 hv cycles off", hv_start_en, 0);
    chk("R9 still stopped", sw_en, 0);
    tsd = 0;
    step(3);
    chk("R9 restart", sw_en, 1);

    // R10 undervoltage
    step((SS + 2) * P);
    vcc_above_off = 0; vcc_above_on = 0;
    step(2);
    chk("R10 uvlo stop", sw_en, 0);
    chk("R10 uvlo charging", hv_start_en, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule